// File: doc/BRIEF.md
# Control-Flow and Conditional-Move Resolver

This block sits in the execute stage of a 64-bit RISC pipeline. It decides what happens to the program counter and to the link and conditional-move write paths. The decoder gives it a decoded operation class. It also receives the current PC, the two source operand values (Ra and Rb), the signed branch displacement, the jump hint and the index of the link destination register. From these it works out whether control transfers, the next PC, the return address with its write enable, and a write enable for a conditional move.

One zero-relative condition evaluator serves both conditional branches and conditional moves. It tests Ra against zero as a signed two's-complement number. Branch targets are relative to the PC of the following instruction. Register jumps take their target from Rb with the alignment bits cleared. Branch-to-subroutine and register jumps both produce a link write, unless the link index names the discard register.

With the default `REGISTERED = 1`, every output comes from a register loaded on the rising clock edge that samples the inputs. Setting it to 0 gives a purely combinational variant.

Top module: `cfres_resolver`

## Requirements
- R1: While `rst_n` is low, all outputs are zero (registered variant).
- R2: Condition codes on `cc`, with Ra read as signed: 0 = zero, 1 = non-zero, 2 = negative, 3 = negative or zero, 4 = positive, 5 = zero or positive. Codes 6 and 7 are never satisfied.
- R3: Operation code 1 (conditional branch) is taken exactly when the condition holds. Its target is PC+4 plus the sign-extended 21-bit displacement times 4.
- R4: Operation code 2 (unconditional branch) is always taken to the same relative target. It requests no link write and no move.
- R5: Operation code 3 (branch-to-subroutine) is taken to the relative target and writes a link value. `link_val` always carries PC+4.
- R6: Operation code 4 (register jump) is taken to Rb with its low two bits forced to zero, and writes a link value. The 16-bit hint has no effect on any output.
- R7: A link index of 31 suppresses `link_we` for operation codes 3 and 4.
- R8: When nothing is taken (code 0 no-op, code 5, or a failed conditional branch), `next_pc` is PC+4.
- R9: Operation code 5 (conditional move) raises `cmov_we` exactly when the condition holds. It is never taken and never writes a link.
- R10: Outputs change one clock edge after the inputs that produce them, and hold between edges.
- R11: All address sums wrap modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 3 | Operation class (0 no-op, 1 cond branch, 2 branch, 3 subroutine branch, 4 register jump, 5 cond move) |
| cc | input | 3 | Condition code (see R2) |
| link_idx | input | 5 | Link destination register index |
| pc | input | 64 | PC of the instruction |
| ra_val | input | 64 | Value tested against zero |
| rb_val | input | 64 | Register jump target |
| disp | input | 21 | Signed word displacement |
| hint | input | 16 | Jump hint (ignored) |
| taken | output | 1 | Control transfers |
| next_pc | output | 64 | Next fetch address |
| link_val | output | 64 | Return address (PC+4) |
| link_we | output | 1 | Link write enable |
| cmov_we | output | 1 | Conditional-move write enable |

## Verification
The assertions check the following on every cycle:
- the link write is suppressed for index 31;
- a subroutine branch writes PC+4;
- a register jump is taken to an aligned address;
- an unconditional branch is always taken;
- a no-op or conditional move falls through to PC+4;
- a move request never coincides with a taken transfer or a link write;
- codes 6 and 7 never take.

Only the bench scenarios can show the rest. These are the exact relative target arithmetic, including negative and extreme displacements and address wrap, the full truth table of each condition code on zero, positive, negative and most-negative operands, the fact that the hint has no effect, and the one-edge latency.

// File: rtl/cfres_pkg.sv
`timescale 1ns/1ps
package cfres_pkg;
   localparam int OP_W = 3;
   localparam int CC_W = 3;

   localparam logic [OP_W-1:0] OP_NOP   = 3'd0;
   localparam logic [OP_W-1:0] OP_BCOND = 3'd1;
   localparam logic [OP_W-1:0] OP_BR    = 3'd2;
   localparam logic [OP_W-1:0] OP_BSR   = 3'd3;
   localparam logic [OP_W-1:0] OP_JUMP  = 3'd4;
   localparam logic [OP_W-1:0] OP_CMOV  = 3'd5;

   localparam logic [CC_W-1:0] CC_ZERO = 3'd0;
   localparam logic [CC_W-1:0] CC_NZ   = 3'd1;
   localparam logic [CC_W-1:0] CC_NEG  = 3'd2;
   localparam logic [CC_W-1:0] CC_NPOS = 3'd3;
   localparam logic [CC_W-1:0] CC_POS  = 3'd4;
   localparam logic [CC_W-1:0] CC_NNEG = 3'd5;
endpackage

// File: rtl/cfres_cond_eval.sv
`timescale 1ns/1ps
module cfres_cond_eval
   import cfres_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [XLEN-1:0] value,
   input  logic [CC_W-1:0] cc,
   output logic            hit
);
   logic is_zero;
   logic is_neg;

   assign is_zero = (value == '0);
   assign is_neg  = value[XLEN-1];

   always_comb begin
      unique case (cc)
         CC_ZERO: hit = is_zero;
         CC_NZ:   hit = !is_zero;
         CC_NEG:  hit = is_neg;
         CC_NPOS: hit = is_neg || is_zero;
         CC_POS:  hit = !is_neg && !is_zero;
         CC_NNEG: hit = !is_neg;
         default: hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/cfres_target.sv
`timescale 1ns/1ps
module cfres_target #(
   parameter int XLEN       = 64,
   parameter int DISP_W     = 21,
   parameter int INSN_BYTES = 4
) (
   input  logic [XLEN-1:0]   pc,
   input  logic [DISP_W-1:0] disp,
   input  logic [XLEN-1:0]   rb,
   output logic [XLEN-1:0]   seq_pc,
   output logic [XLEN-1:0]   rel_tgt,
   output logic [XLEN-1:0]   reg_tgt
);
   localparam int ALIGN_BITS = $clog2(INSN_BYTES);
   localparam int EXT_W      = XLEN - DISP_W;

   logic [XLEN-1:0] disp_ext;

   assign seq_pc   = pc + XLEN'(INSN_BYTES);
   assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
   assign rel_tgt  = seq_pc + (disp_ext << ALIGN_BITS);

   generate
      if (ALIGN_BITS == 0) begin : g_no_align
         assign reg_tgt = rb;
      end else begin : g_align
         logic unused_rb_low;
         assign unused_rb_low = ^rb[ALIGN_BITS-1:0];
         assign reg_tgt = {rb[XLEN-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
      end
   endgenerate
endmodule

// File: rtl/cfres_link_ctl.sv
`timescale 1ns/1ps
module cfres_link_ctl
   import cfres_pkg::*;
#(
   parameter int IDX_W       = 5,
   parameter int DISCARD_IDX = 31
) (
   input  logic [OP_W-1:0]  op,
   input  logic [IDX_W-1:0] link_idx,
   output logic             link_req
);
   logic writes_link;
   logic discarded;

   assign writes_link = (op == OP_BSR) || (op == OP_JUMP);
   assign discarded   = (link_idx == IDX_W'(DISCARD_IDX));
   assign link_req    = writes_link && !discarded;
endmodule

// File: rtl/cfres_resolver.sv
`timescale 1ns/1ps
module cfres_resolver
   import cfres_pkg::*;
#(
   parameter int XLEN        = 64,
   parameter int DISP_W      = 21,
   parameter int HINT_W      = 16,
   parameter int IDX_W       = 5,
   parameter int DISCARD_IDX = 31,
   parameter int INSN_BYTES  = 4,
   parameter bit REGISTERED  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [OP_W-1:0]   op,
   input  logic [CC_W-1:0]   cc,
   input  logic [IDX_W-1:0]  link_idx,
   input  logic [XLEN-1:0]   pc,
   input  logic [XLEN-1:0]   ra_val,
   input  logic [XLEN-1:0]   rb_val,
   input  logic [DISP_W-1:0] disp,
   input  logic [HINT_W-1:0] hint,
   output logic              taken,
   output logic [XLEN-1:0]   next_pc,
   output logic [XLEN-1:0]   link_val,
   output logic              link_we,
   output logic              cmov_we
);
   localparam int ALIGN_BITS = $clog2(INSN_BYTES);

   generate
      if ((1 << ALIGN_BITS) != INSN_BYTES) begin : g_bad_insn
         $error("INSN_BYTES must be a power of two");
      end
      if (XLEN < DISP_W + ALIGN_BITS + 1) begin : g_bad_xlen
         $error("XLEN too narrow for the scaled displacement");
      end
      if (DISCARD_IDX < 0 || DISCARD_IDX >= (1 << IDX_W)) begin : g_bad_idx
         $error("DISCARD_IDX outside the index range");
      end
   endgenerate

   logic unused_hint;
   assign unused_hint = ^hint;

   logic            cond_hit;
   logic            link_req;
   logic [XLEN-1:0] seq_pc;
   logic [XLEN-1:0] rel_tgt;
   logic [XLEN-1:0] reg_tgt;

   cfres_cond_eval #(.XLEN(XLEN)) u_cond (
      .value (ra_val),
      .cc    (cc),
      .hit   (cond_hit)
   );

   cfres_target #(
      .XLEN       (XLEN),
      .DISP_W     (DISP_W),
      .INSN_BYTES (INSN_BYTES)
   ) u_target (
      .pc      (pc),
      .disp    (disp),
      .rb      (rb_val),
      .seq_pc  (seq_pc),
      .rel_tgt (rel_tgt),
      .reg_tgt (reg_tgt)
   );

   cfres_link_ctl #(
      .IDX_W       (IDX_W),
      .DISCARD_IDX (DISCARD_IDX)
   ) u_link (
      .op       (op),
      .link_idx (link_idx),
      .link_req (link_req)
   );

   logic            d_taken;
   logic [XLEN-1:0] d_next;
   logic            d_cmov;

   always_comb begin
      d_taken = 1'b0;
      d_next  = seq_pc;
      d_cmov  = 1'b0;
      unique case (op)
         OP_BCOND: begin
            d_taken = cond_hit;
            if (cond_hit) d_next = rel_tgt;
         end
         OP_BR, OP_BSR: begin
            d_taken = 1'b1;
            d_next  = rel_tgt;
         end
         OP_JUMP: begin
            d_taken = 1'b1;
            d_next  = reg_tgt;
         end
         OP_CMOV: d_cmov = cond_hit;
         default: ;
      endcase
   end

   generate
      if (REGISTERED) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               taken    <= 1'b0;
               next_pc  <= '0;
               link_val <= '0;
               link_we  <= 1'b0;
               cmov_we  <= 1'b0;
            end else begin
               taken    <= d_taken;
               next_pc  <= d_next;
               link_val <= seq_pc;
               link_we  <= link_req;
               cmov_we  <= d_cmov;
            end
         end
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign taken    = d_taken;
         assign next_pc  = d_next;
         assign link_val = seq_pc;
         assign link_we  = link_req;
         assign cmov_we  = d_cmov;
      end
   endgenerate
endmodule

// File: rtl/cfres_resolver_chk.sv
`timescale 1ns/1ps
module cfres_resolver_chk
   import cfres_pkg::*;
#(
   parameter int XLEN        = 64,
   parameter int IDX_W       = 5,
   parameter int DISCARD_IDX = 31,
   parameter int INSN_BYTES  = 4,
   parameter bit REGISTERED  = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic [OP_W-1:0]  op,
   input logic [CC_W-1:0]  cc,
   input logic [IDX_W-1:0] link_idx,
   input logic [XLEN-1:0]  pc,
   input logic             taken,
   input logic [XLEN-1:0]  next_pc,
   input logic [XLEN-1:0]  link_val,
   input logic             link_we,
   input logic             cmov_we
);
   localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);
   localparam logic [IDX_W-1:0] DISC = IDX_W'(DISCARD_IDX);

   AST_MOVE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      cmov_we |-> (!taken && !link_we)); // R9

   generate
      if (REGISTERED) begin : g_seq
         AST_LINK_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
            ((op == OP_BSR || op == OP_JUMP) && link_idx == DISC) |=> !link_we); // R7
         AST_CALL_LINK: assert property (@(posedge clk) disable iff (!rst_n)
            (op == OP_BSR && link_idx != DISC) |=> (link_we && taken && link_val == $past(pc) + STEP)); // R5
         AST_JUMP_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
            (op == OP_JUMP) |=> (taken && next_pc[1:0] == 2'b00)); // R6
         AST_BRANCH_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
            (op == OP_BR) |=> (taken && !link_we && !cmov_we)); // R4
         AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
            (op == OP_NOP || op == OP_CMOV) |=> (!taken && next_pc == $past(pc) + STEP)); // R8
         AST_UNUSED_CODES: assert property (@(posedge clk) disable iff (!rst_n)
            (op == OP_BCOND && cc > 3'd5) |=> !taken); // R2
      end else begin : g_comb
         AST_LINK_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
            ((op == OP_BSR || op == OP_JUMP) && link_idx == DISC) |-> !link_we); // R7
         AST_JUMP_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
            (op == OP_JUMP) |-> (taken && next_pc[1:0] == 2'b00)); // R6
         AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
            (op == OP_NOP || op == OP_CMOV) |-> (!taken && next_pc == pc + STEP)); // R8
      end
   endgenerate
endmodule

bind cfres_resolver cfres_resolver_chk #(
   .XLEN        (XLEN),
   .IDX_W       (IDX_W),
   .DISCARD_IDX (DISCARD_IDX),
   .INSN_BYTES  (INSN_BYTES),
   .REGISTERED  (REGISTERED)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .op       (op),
   .cc       (cc),
   .link_idx (link_idx),
   .pc       (pc),
   .taken    (taken),
   .next_pc  (next_pc),
   .link_val (link_val),
   .link_we  (link_we),
   .cmov_we  (cmov_we)
);

// File: tb/cfres_resolver_bench.sv
`timescale 1ns/1ps
module cfres_resolver_bench;
   import cfres_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  op = '0;
   logic [2:0]  cc = '0;
   logic [4:0]  link_idx = '0;
   logic [63:0] pc = '0;
   logic [63:0] ra_val = '0;
   logic [63:0] rb_val = '0;
   logic [20:0] disp = '0;
   logic [15:0] hint = '0;
   logic        taken;
   logic [63:0] next_pc;
   logic [63:0] link_val;
   logic        link_we;
   logic        cmov_we;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic        p_taken = 1'b0;
   logic [63:0] p_next = '0;
   logic [63:0] p_link = '0;
   logic        p_lwe = 1'b0;
   logic        p_cwe = 1'b0;

   always #10 clk = ~clk;

   cfres_resolver u_cfres_resolver (
      .clk(clk), .rst_n(rst_n), .op(op), .cc(cc), .link_idx(link_idx),
      .pc(pc), .ra_val(ra_val), .rb_val(rb_val), .disp(disp), .hint(hint),
      .taken(taken), .next_pc(next_pc), .link_val(link_val),
      .link_we(link_we), .cmov_we(cmov_we)
   );

   task automatic chk(input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic bit cond_ok(input logic [2:0] c, input logic [63:0] v);
      longint s;
      s = longint'(v);
      case (c)
         3'd0: return s == 0;
         3'd1: return s != 0;
         3'd2: return s < 0;
         3'd3: return s <= 0;
         3'd4: return s > 0;
         3'd5: return s >= 0;
         default: return 1'b0;
      endcase
   endfunction

   function automatic string tag_of(input logic [2:0] o);
      case (o)
         OP_BCOND: return "R3";
         OP_BR:    return "R4";
         OP_BSR:   return "R5";
         OP_JUMP:  return "R6";
         OP_CMOV:  return "R9";
         default:  return "R8";
      endcase
   endfunction

   task automatic apply(input string tag, input logic [2:0] o, input logic [2:0] c,
                        input logic [4:0] li, input logic [63:0] p,
                        input logic [63:0] ra, input logic [63:0] rb,
                        input logic [20:0] d, input logic [15:0] h);
      logic        e_t, e_lw, e_cw;
      logic [63:0] e_np, e_lv, seq, rel;
      bit          hit;
      string       t;
      t = (tag == "") ? tag_of(o) : tag;
      op = o; cc = c; link_idx = li; pc = p; ra_val = ra; rb_val = rb;
      disp = d; hint = h;
      seq = p + 64'd4;
      rel = seq + 64'(longint'($signed(d)) * 4);
      hit = cond_ok(c, ra);
      e_t = 1'b0; e_np = seq; e_lv = seq; e_lw = 1'b0; e_cw = 1'b0;
      case (o)
         OP_BCOND: begin e_t = hit; if (hit) e_np = rel; end
         OP_BR:    begin e_t = 1'b1; e_np = rel; end
         OP_BSR:   begin e_t = 1'b1; e_np = rel; e_lw = (li != 5'd31); end
         OP_JUMP:  begin e_t = 1'b1; e_np = {rb[63:2], 2'b00}; e_lw = (li != 5'd31); end
         OP_CMOV:  e_cw = hit;
         default: ;
      endcase
      #5;
      chk("R10", "hold taken", 64'(taken), 64'(p_taken));
      chk("R10", "hold next_pc", next_pc, p_next);
      @(negedge clk);
      chk(t, "taken", 64'(taken), 64'(e_t));
      chk(t, "next_pc", next_pc, e_np);
      chk(t, "link_val", link_val, e_lv);
      chk((li == 5'd31 && (o == OP_BSR || o == OP_JUMP)) ? "R7" : t, "link_we",
          64'(link_we), 64'(e_lw));
      chk(t, "cmov_we", 64'(cmov_we), 64'(e_cw));
      p_taken = e_t; p_next = e_np; p_link = e_lv; p_lwe = e_lw; p_cwe = e_cw;
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [63:0] vals [4];
      vals[0] = 64'd0; vals[1] = 64'd7;
      vals[2] = 64'hFFFF_FFFF_FFFF_FFFE; vals[3] = 64'h8000_0000_0000_0000;
      op = OP_BR; cc = 3'd1; link_idx = 5'd26; pc = 64'h1234; ra_val = 64'd5;
      repeat (3) @(negedge clk);
      chk("R1", "reset taken", 64'(taken), 64'd0);
      chk("R1", "reset next_pc", next_pc, 64'd0);
      chk("R1", "reset link_val", link_val, 64'd0);
      chk("R1", "reset link_we", 64'(link_we), 64'd0);
      chk("R1", "reset cmov_we", 64'(cmov_we), 64'd0);
      rst_n = 1'b1;

      // R2 condition table on both consumers
      for (int c = 0; c < 8; c++) begin
         for (int v = 0; v < 4; v++) begin
            apply("R2", OP_BCOND, 3'(c), 5'd0, 64'h1000, vals[v], 64'd0, 21'd8, 16'd0);
            apply("R2", OP_CMOV, 3'(c), 5'd0, 64'h2000, vals[v], 64'd3, 21'd0, 16'd0);
         end
      end
      apply("R3", OP_BCOND, 3'd1, 5'd0, 64'h800, 64'd1, 64'd0, 21'h1F_FFFF, 16'd0);
      apply("R3", OP_BCOND, 3'd1, 5'd0, 64'h800, 64'd1, 64'd0, 21'h0F_FFFF, 16'd0);
      apply("R3", OP_BCOND, 3'd1, 5'd0, 64'h800000, 64'd1, 64'd0, 21'h10_0000, 16'd0);
      apply("R4", OP_BR, 3'd0, 5'd26, 64'h400, 64'd9, 64'd0, 21'd100, 16'd0);
      apply("R5", OP_BSR, 3'd0, 5'd26, 64'h800, 64'd0, 64'd0, 21'd69, 16'd0);
      apply("R7", OP_BSR, 3'd0, 5'd31, 64'h800, 64'd0, 64'd0, 21'd69, 16'd0);
      apply("R6", OP_JUMP, 3'd0, 5'd26, 64'h900, 64'd0, 64'h0000_0000_0000_1237, 21'd0, 16'h0000);
      apply("R6", OP_JUMP, 3'd0, 5'd26, 64'h900, 64'd0, 64'h0000_0000_0000_1237, 21'd0, 16'hFFFF);
      apply("R7", OP_JUMP, 3'd0, 5'd31, 64'h91C, 64'd0, 64'h804, 21'd0, 16'h0001);
      apply("R8", OP_NOP, 3'd0, 5'd26, 64'h3000, 64'd0, 64'd0, 21'd55, 16'd0);
      apply("R11", OP_NOP, 3'd0, 5'd0, 64'hFFFF_FFFF_FFFF_FFFC, 64'd0, 64'd0, 21'd0, 16'd0);
      apply("R11", OP_BR, 3'd0, 5'd0, 64'd0, 64'd0, 64'd0, 21'h1F_FFF0, 16'd0);
      apply("R11", OP_BSR, 3'd0, 5'd26, 64'hFFFF_FFFF_FFFF_FFF8, 64'd0, 64'd0, 21'd4, 16'd0);

      for (int i = 0; i < 400; i++) begin
         apply("", 3'($urandom_range(0, 5)), 3'($urandom), 5'($urandom),
               {$urandom, $urandom}, ($urandom_range(0, 3) == 0) ? 64'd0 : {$urandom, $urandom},
               {$urandom, $urandom}, 21'($urandom), 16'($urandom));
      end

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule